// File: doc/BRIEF.md
# Display Encoder Bus-Switch Sequencer

This block drives the command interface of an I2C master to run one fixed exchange with a serial display encoder: it tells the encoder to route its downstream bus to one of the two DDC channels. A single start pulse triggers the whole exchange. First the bus-select mask goes into the encoder's argument register, then a stop is issued. Next the switch opcode goes into the encoder's command register. After that the encoder's status register is read repeatedly while it reports "pending", up to a bounded number of reads. A closing stop follows, and the block ends with a one-cycle completion pulse that carries a pass or fail verdict.

The master itself is outside the block. The block sees it as a request/acknowledge port. A request and its command fields stay stable until the master returns a one-cycle acknowledge. The acknowledge can carry a no-acknowledge flag and, for reads, the byte that was read. If the target address is not one of the two encoder addresses, the block reports failure at once and puts nothing on the bus.

Top module: `enc_bus_switch_seq`

## Requirements
- R1: During and straight after reset, done_o, ok_o, err_o and mst_req_o are all low.
- R2: The first command is a write (mst_op_o = 2'b00) of the bus-select mask to index 0x07 at the latched address. The mask is 0x02 when ddc_sel_i = 0 (DDC1) and 0x04 when ddc_sel_i = 1 (DDC2). Bit 0 (PROM) is never set.
- R3: A stop command (mst_op_o = 2'b10) follows the mask write and comes before the opcode write.
- R4: After that first stop, a write of opcode 0x7A to index 0x08 is issued.
- R5: Status is read (mst_op_o = 2'b01) from index 0x09. Reading repeats only while the byte returned is 0x04 (pending), with at most 3 reads per sequence.
- R6: After the last status read, one stop is issued and then done_o pulses. ok_o is high with done_o exactly when the final status byte was 0x01.
- R7: A final status other than 0x01, including 0x04 on the third read, gives err_o high with done_o and ok_o low.
- R8: A no-acknowledge on any write or read ends the sequence. The next command is a stop, then done_o pulses with err_o high and ok_o low.
- R9: If enc_addr_i is neither 7'h38 nor 7'h39 (byte addresses 0x70/0x72), start_i gives a done_o pulse with err_o in the next cycle and no master request at all.
- R10: done_o lasts one clock, and ok_o/err_o are high only together with done_o. A start_i pulse that arrives while a sequence is running is ignored: the commands issued and the verdict do not change.
- R11: While mst_req_o is high and mst_ack_i is low, mst_op_o, mst_addr_o, mst_idx_o and mst_wdata_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that begins a sequence |
| enc_addr_i | input | 7 | 7-bit encoder address, sampled on start |
| ddc_sel_i | input | 1 | DDC channel: 0 = DDC1, 1 = DDC2 |
| mst_req_o | output | 1 | Command request to the master |
| mst_op_o | output | 2 | 00 write, 01 read, 10 stop |
| mst_addr_o | output | 7 | Target address for the command |
| mst_idx_o | output | 8 | Encoder register index |
| mst_wdata_o | output | 8 | Byte to write |
| mst_ack_i | input | 1 | One-cycle completion from the master |
| mst_nack_i | input | 1 | Target did not acknowledge; valid with mst_ack_i |
| mst_rdata_i | input | 8 | Read byte; valid with mst_ack_i |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ok_o | output | 1 | Success verdict, valid with done_o |
| err_o | output | 1 | Failure verdict, valid with done_o |

## Verification
The assertions assume that the master raises mst_ack_i only while mst_req_o is high, and only for one cycle. They also assume that mst_nack_i and mst_rdata_i are meaningful only in that acknowledge cycle. The bench's master model keeps to this. It counts a programmable latency from the request and pulses the acknowledge once. It then drops the acknowledge for at least one cycle before it looks at the next request. No-acknowledge is injected only on write and read commands, and start_i is always a single-cycle pulse driven on the falling edge.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_STOP  = 2'b10
  } mst_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PARAM, S_STOP1, S_OPCODE, S_POLL, S_STOP2, S_DONE
  } seq_state_e;

  localparam logic [7:0] IDX_ARG    = 8'h07;
  localparam logic [7:0] IDX_CMD    = 8'h08;
  localparam logic [7:0] IDX_STAT   = 8'h09;
  localparam logic [7:0] OPC_SWITCH = 8'h7A;
  localparam logic [7:0] ST_SUCCESS = 8'h01;
  localparam logic [7:0] ST_PENDING = 8'h04;
  localparam logic [6:0] ENC_ADDR_A = 7'h38;
  localparam logic [6:0] ENC_ADDR_B = 7'h39;
endpackage

// File: rtl/ebs_param_gen.sv
module ebs_param_gen #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned MASK_W = 8
) (
  input  logic              sel_i,
  input  logic [6:0]        addr_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              addr_ok_o
);
  import ebs_pkg::*;

  // bit 0 is the PROM route; DDC channels start at bit 1
  logic [NUM_CH-1:0] ch_hit;
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_hit[g] = (g == 0) ? !sel_i : sel_i;
  end

  always_comb begin
    mask_o = '0;
    mask_o[NUM_CH:1] = ch_hit;
  end

  assign addr_ok_o = (addr_i == ENC_ADDR_A) || (addr_i == ENC_ADDR_B);
endmodule

// File: rtl/ebs_poll_ctr.sv
module ebs_poll_ctr #(
  parameter int unsigned MAX_POLLS = 3,
  localparam int unsigned CW = $clog2(MAX_POLLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  // high while the read now in flight is the final permitted one
  assign last_o = (cnt_q == CW'(MAX_POLLS - 1));
endmodule

// File: rtl/ebs_ctrl.sv
module ebs_ctrl #(
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [6:0]        addr_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              addr_ok_i,
  input  logic              poll_last_i,
  output logic              poll_clr_o,
  output logic              poll_inc_o,
  output logic              mst_req_o,
  output logic [1:0]        mst_op_o,
  output logic [6:0]        mst_addr_o,
  output logic [7:0]        mst_idx_o,
  output logic [7:0]        mst_wdata_o,
  input  logic              mst_ack_i,
  input  logic              mst_nack_i,
  input  logic [7:0]        mst_rdata_i,
  output logic              done_o,
  output logic              ok_o,
  output logic              err_o
);
  import ebs_pkg::*;

  seq_state_e        state_q, state_d;
  logic [6:0]        addr_q;
  logic [MASK_W-1:0] mask_q;
  logic [7:0]        stat_q;
  logic              fail_q, fail_d;
  logic              take;

  assign take = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    fail_d  = fail_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        fail_d  = !addr_ok_i;
        state_d = addr_ok_i ? S_PARAM : S_DONE;
      end
      S_PARAM: if (mst_ack_i) begin
        fail_d  = mst_nack_i;
        state_d = mst_nack_i ? S_STOP2 : S_STOP1;
      end
      S_STOP1: if (mst_ack_i) state_d = S_OPCODE;
      S_OPCODE: if (mst_ack_i) begin
        fail_d  = mst_nack_i;
        state_d = mst_nack_i ? S_STOP2 : S_POLL;
      end
      S_POLL: if (mst_ack_i) begin
        if (mst_nack_i) begin
          fail_d  = 1'b1;
          state_d = S_STOP2;
        end else if (mst_rdata_i != ST_PENDING || poll_last_i) begin
          state_d = S_STOP2;
        end
      end
      S_STOP2: if (mst_ack_i) state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      fail_q  <= 1'b0;
      addr_q  <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
      if (take) begin
        addr_q <= addr_i;
        mask_q <= mask_i;
        stat_q <= '0;
      end else if (state_q == S_POLL && mst_ack_i && !mst_nack_i) begin
        stat_q <= mst_rdata_i;
      end
    end
  end

  assign poll_clr_o = take;
  assign poll_inc_o = (state_q == S_POLL) && mst_ack_i;

  always_comb begin
    mst_req_o   = 1'b1;
    mst_op_o    = OP_WRITE;
    mst_idx_o   = '0;
    mst_wdata_o = '0;
    unique case (state_q)
      S_PARAM: begin
        mst_idx_o   = IDX_ARG;
        mst_wdata_o = 8'(mask_q);
      end
      S_OPCODE: begin
        mst_idx_o   = IDX_CMD;
        mst_wdata_o = OPC_SWITCH;
      end
      S_POLL: begin
        mst_op_o  = OP_READ;
        mst_idx_o = IDX_STAT;
      end
      S_STOP1, S_STOP2: mst_op_o = OP_STOP;
      default: mst_req_o = 1'b0;
    endcase
  end

  assign mst_addr_o = addr_q;
  assign done_o     = (state_q == S_DONE);
  assign ok_o       = done_o && !fail_q && (stat_q == ST_SUCCESS);
  assign err_o      = done_o && !ok_o;
endmodule

// File: rtl/enc_bus_switch_seq.sv
module enc_bus_switch_seq #(
  parameter int unsigned MAX_POLLS = 3,
  parameter int unsigned NUM_CH    = 2,
  localparam int unsigned MASK_W   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [6:0] enc_addr_i,
  input  logic       ddc_sel_i,
  output logic       mst_req_o,
  output logic [1:0] mst_op_o,
  output logic [6:0] mst_addr_o,
  output logic [7:0] mst_idx_o,
  output logic [7:0] mst_wdata_o,
  input  logic       mst_ack_i,
  input  logic       mst_nack_i,
  input  logic [7:0] mst_rdata_i,
  output logic       done_o,
  output logic       ok_o,
  output logic       err_o
);
  logic [MASK_W-1:0] mask;
  logic              addr_ok, poll_clr, poll_inc, poll_last;

  ebs_param_gen #(.NUM_CH(NUM_CH), .MASK_W(MASK_W)) u_param (
    .sel_i     (ddc_sel_i),
    .addr_i    (enc_addr_i),
    .mask_o    (mask),
    .addr_ok_o (addr_ok)
  );

  ebs_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  ebs_ctrl #(.MASK_W(MASK_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .addr_i      (enc_addr_i),
    .mask_i      (mask),
    .addr_ok_i   (addr_ok),
    .poll_last_i (poll_last),
    .poll_clr_o  (poll_clr),
    .poll_inc_o  (poll_inc),
    .mst_req_o   (mst_req_o),
    .mst_op_o    (mst_op_o),
    .mst_addr_o  (mst_addr_o),
    .mst_idx_o   (mst_idx_o),
    .mst_wdata_o (mst_wdata_o),
    .mst_ack_i   (mst_ack_i),
    .mst_nack_i  (mst_nack_i),
    .mst_rdata_i (mst_rdata_i),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .err_o       (err_o)
  );
endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
  parameter int unsigned MAX_POLLS = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mst_req_o,
  input logic [1:0] mst_op_o,
  input logic [6:0] mst_addr_o,
  input logic [7:0] mst_idx_o,
  input logic [7:0] mst_wdata_o,
  input logic       mst_ack_i,
  input logic       done_o,
  input logic       ok_o,
  input logic       err_o
);
  logic [7:0] reads_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          reads_q <= '0;
    else if (done_o)                                      reads_q <= '0;
    else if (mst_req_o && mst_ack_i && mst_op_o == 2'b01) reads_q <= reads_q + 1'b1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && !mst_ack_i |=> mst_req_o && $stable(mst_op_o) && $stable(mst_addr_o)
      && $stable(mst_idx_o) && $stable(mst_wdata_o)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

  AST_VERDICT_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o || err_o) |-> done_o && (ok_o != err_o)); // R10

  AST_ADDR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o |-> (mst_addr_o == 7'h38 || mst_addr_o == 7'h39)); // R9

  AST_OPCODE_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && mst_op_o == 2'b00 && mst_idx_o == 8'h08 |-> mst_wdata_o == 8'h7A); // R4

  AST_MASK_ONE_DDC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_req_o && mst_op_o == 2'b00 && mst_idx_o == 8'h07
      |-> $onehot0(mst_wdata_o) && (mst_wdata_o[2:1] != 2'b00)); // R2

  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reads_q <= 8'(MAX_POLLS)); // R5

  AST_NO_REQ_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mst_req_o); // R6
endmodule

bind enc_bus_switch_seq ebs_checker #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mst_req_o   (mst_req_o),
  .mst_op_o    (mst_op_o),
  .mst_addr_o  (mst_addr_o),
  .mst_idx_o   (mst_idx_o),
  .mst_wdata_o (mst_wdata_o),
  .mst_ack_i   (mst_ack_i),
  .done_o      (done_o),
  .ok_o        (ok_o),
  .err_o       (err_o)
);

// File: tb/enc_bus_switch_seq_tb.sv
module enc_bus_switch_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] enc_addr_i = '0;
  logic       ddc_sel_i = 1'b0;
  logic       mst_req_o;
  logic [1:0] mst_op_o;
  logic [6:0] mst_addr_o;
  logic [7:0] mst_idx_o, mst_wdata_o;
  logic       mst_ack_i = 1'b0, mst_nack_i = 1'b0;
  logic [7:0] mst_rdata_i = '0;
  logic       done_o, ok_o, err_o;

  always #4 clk_i = ~clk_i;

  enc_bus_switch_seq u_dut (.*);

  typedef struct {
    logic [1:0] op;
    logic [7:0] idx;
    logic [7:0] dat;
    string      tag;
  } txn_t;

  txn_t       exp_q[$];
  int         n_tests = 0, n_fail = 0;
  int         lat = 1, dcnt = 0, tx_i = 0, rd_i = 0, nack_at = -1, done_cnt = 0;
  logic [7:0] resp[3];
  logic [6:0] exp_addr;
  logic       exp_ok;
  string      exp_tag;
  logic       done_prev = 1'b0;
  logic [1:0] h_op;
  logic [7:0] h_idx, h_dat;

  task automatic chk(input bit cond, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] idx,
                      input logic [7:0] dat, input string tag);
    txn_t t;
    t.op = op; t.idx = idx; t.dat = dat; t.tag = tag;
    exp_q.push_back(t);
  endtask

  // master model and monitor of commands
  always @(negedge clk_i) begin
    if (mst_ack_i) begin
      mst_ack_i  = 1'b0;
      mst_nack_i = 1'b0;
      dcnt = 0;
    end else if (rst_ni && mst_req_o) begin
      if (dcnt > 0)
        chk(h_op == mst_op_o && h_idx == mst_idx_o && h_dat == mst_wdata_o,
            "R11", "held command", {mst_op_o, mst_idx_o}, {h_op, h_idx});
      h_op = mst_op_o; h_idx = mst_idx_o; h_dat = mst_wdata_o;
      if (dcnt >= lat) begin
        mst_ack_i  = 1'b1;
        mst_nack_i = (tx_i == nack_at) && (mst_op_o != 2'b10);
        if (mst_op_o == 2'b01) begin
          mst_rdata_i = (rd_i < 3) ? resp[rd_i] : 8'hFF;
          rd_i++;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected command op", mst_op_o, 0);
        end else begin
          txn_t t;
          t = exp_q.pop_front();
          chk(mst_op_o == t.op, t.tag, "op", mst_op_o, t.op);
          chk(mst_addr_o == exp_addr, t.tag, "addr", mst_addr_o, exp_addr);
          if (t.op != 2'b10) chk(mst_idx_o == t.idx, t.tag, "idx", mst_idx_o, t.idx);
          if (t.op == 2'b00) chk(mst_wdata_o == t.dat, t.tag, "wdata", mst_wdata_o, t.dat);
        end
        tx_i++;
      end else begin
        dcnt++;
      end
    end
  end

  // verdict monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_prev) chk(!done_o, "R10", "done width", done_o, 0);
      if (!done_o) chk(!ok_o && !err_o, "R10", "verdict outside done", {ok_o, err_o}, 0);
      if (done_o) begin
        chk(ok_o == exp_ok && err_o == !exp_ok, exp_tag, "ok/err", {ok_o, err_o},
            {exp_ok, !exp_ok});
        chk(exp_q.size() == 0, exp_tag, "commands left", exp_q.size(), 0);
        done_cnt++;
      end
      done_prev = done_o;
    end
  end

  task automatic run(input logic [6:0] a, input bit s, input logic [7:0] s0,
                     input logic [7:0] s1, input logic [7:0] s2, input int nk,
                     input int l, input bit poke);
    bit         ab = 1'b0;
    logic [7:0] last = 8'h00;
    int         d0 = done_cnt;
    resp[0] = s0; resp[1] = s1; resp[2] = s2;
    nack_at = nk; lat = l; tx_i = 0; rd_i = 0; exp_addr = a;
    exp_tag = "R6";
    if (!(a == 7'h38 || a == 7'h39)) begin
      exp_ok = 1'b0; exp_tag = "R9";
    end else begin
      push(2'b00, 8'h07, s ? 8'h04 : 8'h02, "R2");
      if (nk == 0) ab = 1'b1;
      else begin
        push(2'b10, 8'h00, 8'h00, "R3");
        push(2'b00, 8'h08, 8'h7A, "R4");
        if (nk == 2) ab = 1'b1;
        else begin
          for (int k = 0; k < 3; k++) begin
            push(2'b01, 8'h09, 8'h00, "R5");
            if (nk == 3 + k) begin ab = 1'b1; break; end
            last = resp[k];
            if (last != 8'h04) break;
          end
        end
      end
      push(2'b10, 8'h00, 8'h00, ab ? "R8" : "R6");
      exp_ok = !ab && (last == 8'h01);
      if (ab) exp_tag = "R8";
      else if (!exp_ok) exp_tag = "R7";
    end
    @(negedge clk_i);
    enc_addr_i = a; ddc_sel_i = s; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk_i);
      enc_addr_i = 7'h39; ddc_sel_i = !s; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(done_cnt == d0 + 1, "R10", "done pulses", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!done_o && !ok_o && !err_o && !mst_req_o, "R1", "reset outputs",
        {done_o, ok_o, err_o, mst_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && !mst_req_o, "R1", "after reset", {done_o, mst_req_o}, 0);
    run(7'h38, 1'b0, 8'h01, 8'h00, 8'h00, -1, 1, 1'b0); // R6 immediate success
    run(7'h39, 1'b1, 8'h04, 8'h04, 8'h01, -1, 0, 1'b0); // R5 three reads then success
    run(7'h38, 1'b1, 8'h04, 8'h04, 8'h04, -1, 2, 1'b0); // R7 still pending
    run(7'h39, 1'b0, 8'h04, 8'h02, 8'h01, -1, 1, 1'b0); // R7 other status
    run(7'h38, 1'b0, 8'h01, 8'h00, 8'h00, 0, 1, 1'b0);  // R8 nack on mask write
    run(7'h39, 1'b1, 8'h01, 8'h00, 8'h00, 2, 0, 1'b0);  // R8 nack on opcode
    run(7'h38, 1'b0, 8'h04, 8'h01, 8'h00, 4, 1, 1'b0);  // R8 nack on second read
    run(7'h40, 1'b0, 8'h01, 8'h00, 8'h00, -1, 1, 1'b0); // R9 bad address
    run(7'h38, 1'b1, 8'h04, 8'h01, 8'h00, -1, 2, 1'b1); // R10 start while busy
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule